// File: doc/BRIEF.md
# Exclusive Atomic Increment Master

This block is a master-side sequencer that atomically increments one 32-bit word in memory over an AXI4 interface. It uses an exclusive read followed by an exclusive write. A one-cycle `start` pulse with a target address begins a sequence. The engine first issues a single-beat exclusive read of the word. It then computes the read value plus one and writes the result back with a single-beat exclusive write to the same address, using the same ID and size. Finally it inspects the write response.

If the write response reports that exclusivity was lost, the engine does not finish. It waits for a pseudo-random back-off delay and then repeats the whole read-increment-write pass. The delay window grows after every failure and is capped. After a configured number of failed passes the engine gives up and flags an error. A slave or decode error on either the read or the write ends the sequence at once with the error flag, and a failed read never leads to a write.

The controller is one state machine with the following states:

| State | Action | Transitions |
|---|---|---|
| `ST_IDLE` | Waits for work. | Goes to `ST_AR` on `start`. |
| `ST_AR` | Presents the read address. | Goes to `ST_R` on the AR handshake. |
| `ST_R` | Accepts the read data. | Goes to `ST_WR` on a good response; goes to `ST_ERR` on an error response. |
| `ST_WR` | Presents AW and W. | Goes to `ST_B` once both handshakes have occurred. |
| `ST_B` | Waits for the write response. | Goes to `ST_DONE` on EXOKAY. On OKAY it goes to `ST_WAIT`, or to `ST_ERR` if the retry limit is reached. Goes to `ST_ERR` on SLVERR or DECERR. |
| `ST_WAIT` | Counts down the back-off delay. | Goes to `ST_AR` when the delay has elapsed. |
| `ST_DONE` | Holds for one cycle. | Returns to `ST_IDLE`. |
| `ST_ERR` | Holds for one cycle. | Returns to `ST_IDLE`. |

Top module: `excl_incr_engine`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `m_arvalid`, `m_awvalid`, `m_wvalid` and `m_bready` are all low.
- R2: A `start` pulse in idle captures `addr_in` and raises `m_arvalid` on the next cycle. The read carries `m_araddr`=address, `m_arlock`=1 (exclusive), `m_arsize`=3'b010 (4 bytes), `m_arlen`=0 and `m_arid`=TXN_ID. `m_arvalid` and the address stay stable until `m_arready`.
- R3: The write carries `m_wdata` = read data + 1, taken modulo 2^32 so that 0xFFFFFFFF wraps to 0. It uses the same address, `m_awlock`=1, `m_awid`=TXN_ID, `m_awsize`=3'b010, `m_awlen`=0, `m_wlast`=1 and `m_wstrb`=4'hF.
- R4: AW and W may be accepted in either order or in the same cycle. Each valid stays high until its own handshake. `m_bready` rises only after both handshakes have completed.
- R5: A write response of 2'b01 (EXOKAY) produces a one-cycle `done` pulse with `err` low. `result` holds the written value, and `busy` is low in that cycle.
- R6: A write response of 2'b00 (OKAY) starts a back-off, after which the exclusive read is reissued to the same address. The delay, counted from the B handshake to the new `m_arvalid`, is 1 to mask+1 cycles. The mask is 3 after the first failure and becomes (mask·2+1) after each further failure, capped at 255.
- R7: When the MAX_FAILS-th (default 3) OKAY response arrives, the engine emits a one-cycle `err` pulse with `done` low and issues no further read.
- R8: A write response of 2'b10 or 2'b11 emits `err` at once, with no retry read.
- R9: A read response of 2'b10 or 2'b11 emits `err` and no AW or W is ever presented.
- R10: `start` while busy is ignored. The address in flight is kept, and no extra sequence follows.
- R11: `busy` is high from the cycle after `start` is accepted until the cycle in which `done` or `err` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (idle only) |
| addr_in | input | ADDR_W | Target word address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle failure pulse |
| result | output | 32 | Last value computed for writing |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | ADDR_W | Read address |
| m_arid | output | ID_W | Read ID |
| m_arlen | output | 8 | Read beats minus one (0) |
| m_arsize | output | 3 | Read size code |
| m_arlock | output | 1 | Exclusive read |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | 32 | Read data |
| m_rresp | input | 2 | Read response |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Write address |
| m_awid | output | ID_W | Write ID |
| m_awlen | output | 8 | Write beats minus one (0) |
| m_awsize | output | 3 | Write size code |
| m_awlock | output | 1 | Exclusive write |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Byte strobes |
| m_wlast | output | 1 | Last write beat |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response |

## Verification
The bench drives the write address and data channels in three orders: address first, data first, and both together. A tracker that mishandled any of these would either hang or raise `m_bready` early. The all-ones read value is used to catch an increment that fails to wrap. The bench measures back-off gaps against the growing mask, so an unmasked or non-growing delay shows up as an out-of-range count. It also runs the retry limit through exactly MAX_FAILS exclusive failures, which exposes an off-by-one as an extra or missing read. Error responses on the read and on the write, and a `start` arriving mid-sequence, are checked for a leaked write, a retry or a replaced address.

// File: rtl/excl_incr_pkg.sv
package excl_incr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AR,
        ST_R,
        ST_WR,
        ST_B,
        ST_WAIT,
        ST_DONE,
        ST_ERR
    } eng_state_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_EXOKAY = 2'b01;
    localparam logic [2:0] SIZE_WORD   = 3'b010;
endpackage

// File: rtl/excl_backoff.sv
module excl_backoff #(
    parameter int          CNT_W     = 8,
    parameter int          INIT_MASK = 3,
    parameter logic [15:0] SEED      = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic load_i,
    output logic zero_o
);
    localparam logic [CNT_W-1:0] CAP = '1;

    logic [15:0]      lfsr;
    logic [CNT_W-1:0] win;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr <= SEED;
        end else begin
            lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win <= CNT_W'(INIT_MASK);
            cnt <= '0;
        end else begin
            if (clr_i) begin
                win <= CNT_W'(INIT_MASK);
            end else if (load_i) begin
                win <= (win == CAP) ? CAP : {win[CNT_W-2:0], 1'b1};
            end
            if (load_i) begin
                cnt <= lfsr[CNT_W-1:0] & win;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign zero_o = (cnt == '0);

    // R6
    cnt_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt <= $past(win)));
endmodule

// File: rtl/excl_wr_chan.sv
module excl_wr_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic awready_i,
    input  logic wready_i,
    output logic awvalid_o,
    output logic wvalid_o,
    output logic both_o
);
    logic aw_pend;
    logic w_pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aw_pend <= 1'b0;
            w_pend  <= 1'b0;
        end else if (arm_i) begin
            aw_pend <= 1'b1;
            w_pend  <= 1'b1;
        end else begin
            if (aw_pend && awready_i) aw_pend <= 1'b0;
            if (w_pend && wready_i)   w_pend  <= 1'b0;
        end
    end

    assign awvalid_o = aw_pend;
    assign wvalid_o  = w_pend;
    assign both_o    = (!aw_pend || awready_i) && (!w_pend || wready_i);

    // R4
    aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid_o && !awready_i |=> awvalid_o);
    // R4
    w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid_o && !wready_i |=> wvalid_o);
endmodule

// File: rtl/excl_incr_engine.sv
module excl_incr_engine
    import excl_incr_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter int              ID_W      = 4,
    parameter logic [ID_W-1:0] TXN_ID    = '0,
    parameter int              MAX_FAILS = 3,
    parameter int              BACKOFF_W = 8,
    parameter logic [15:0]     LFSR_SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [31:0]       result,
    output logic              m_arvalid,
    input  logic              m_arready,
    output logic [ADDR_W-1:0] m_araddr,
    output logic [ID_W-1:0]   m_arid,
    output logic [7:0]        m_arlen,
    output logic [2:0]        m_arsize,
    output logic              m_arlock,
    input  logic              m_rvalid,
    output logic              m_rready,
    input  logic [31:0]       m_rdata,
    input  logic [1:0]        m_rresp,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [ADDR_W-1:0] m_awaddr,
    output logic [ID_W-1:0]   m_awid,
    output logic [7:0]        m_awlen,
    output logic [2:0]        m_awsize,
    output logic              m_awlock,
    output logic              m_wvalid,
    input  logic              m_wready,
    output logic [31:0]       m_wdata,
    output logic [3:0]        m_wstrb,
    output logic              m_wlast,
    input  logic              m_bvalid,
    output logic              m_bready,
    input  logic [1:0]        m_bresp
);
    localparam int FAIL_W = $clog2(MAX_FAILS + 1);

    eng_state_e        state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       data_q;
    logic [FAIL_W-1:0] fails_q;
    logic              rd_ok, rd_bad, b_fail, last_fail;
    logic              wr_arm, wr_both, bo_load, bo_clr, bo_zero;

    assign rd_ok     = (state == ST_R) && m_rvalid && !m_rresp[1];
    assign rd_bad    = (state == ST_R) && m_rvalid &&  m_rresp[1];
    assign b_fail    = (state == ST_B) && m_bvalid && (m_bresp == RESP_OKAY);
    assign last_fail = (fails_q == FAIL_W'(MAX_FAILS - 1));
    assign wr_arm    = rd_ok;
    assign bo_clr    = (state == ST_IDLE) && start;
    assign bo_load   = b_fail && !last_fail;

    excl_wr_chan u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (wr_arm),
        .awready_i (m_awready),
        .wready_i  (m_wready),
        .awvalid_o (m_awvalid),
        .wvalid_o  (m_wvalid),
        .both_o    (wr_both)
    );

    excl_backoff #(
        .CNT_W     (BACKOFF_W),
        .INIT_MASK (3),
        .SEED      (LFSR_SEED)
    ) u_bo (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (bo_clr),
        .load_i (bo_load),
        .zero_o (bo_zero)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_AR;
            ST_AR:   if (m_arready) state_nx = ST_R;
            ST_R: begin
                if (rd_bad)     state_nx = ST_ERR;
                else if (rd_ok) state_nx = ST_WR;
            end
            ST_WR:   if (wr_both) state_nx = ST_B;
            ST_B: begin
                if (m_bvalid) begin
                    if (m_bresp == RESP_EXOKAY)    state_nx = ST_DONE;
                    else if (m_bresp == RESP_OKAY) state_nx = last_fail ? ST_ERR : ST_WAIT;
                    else                           state_nx = ST_ERR;
                end
            end
            ST_WAIT: if (bo_zero) state_nx = ST_AR;
            ST_DONE: state_nx = ST_IDLE;
            ST_ERR:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            data_q  <= '0;
            fails_q <= '0;
        end else begin
            if (bo_clr) begin
                addr_q  <= addr_in;
                fails_q <= '0;
            end
            if (rd_ok)  data_q  <= m_rdata + 32'd1;
            if (b_fail) fails_q <= fails_q + 1'b1;
        end
    end

    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        err       = 1'b0;
        m_arvalid = 1'b0;
        m_rready  = 1'b0;
        m_bready  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_AR:   begin busy = 1'b1; m_arvalid = 1'b1; end
            ST_R:    begin busy = 1'b1; m_rready  = 1'b1; end
            ST_WR:   busy = 1'b1;
            ST_B:    begin busy = 1'b1; m_bready  = 1'b1; end
            ST_WAIT: busy = 1'b1;
            ST_DONE: done = 1'b1;
            ST_ERR:  err  = 1'b1;
            default: ;
        endcase
    end

    assign result   = data_q;
    assign m_araddr = addr_q;
    assign m_arid   = TXN_ID;
    assign m_arlen  = 8'd0;
    assign m_arsize = SIZE_WORD;
    assign m_arlock = 1'b1;
    assign m_awaddr = addr_q;
    assign m_awid   = TXN_ID;
    assign m_awlen  = 8'd0;
    assign m_awsize = SIZE_WORD;
    assign m_awlock = 1'b1;
    assign m_wdata  = data_q;
    assign m_wstrb  = 4'hF;
    assign m_wlast  = 1'b1;

    // R2
    ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr));
    // R4
    b_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_bready |-> !m_awvalid && !m_wvalid);
    // R9
    rerr_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_rvalid && m_rready && m_rresp[1] |=> err && !m_awvalid && !m_wvalid);
    // R7
    retry_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_bvalid && m_bready && (m_bresp == RESP_OKAY) && last_fail |=> err);
    // R5
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !err && !busy);
    // R10
    start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(m_araddr));
endmodule

// File: tb/excl_incr_engine_tb.sv
module excl_incr_engine_tb;
    localparam int MAXF = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] addr_in = '0;
    logic        busy, done, err;
    logic [31:0] result;
    logic        m_arvalid, m_arready = 1'b0;
    logic [31:0] m_araddr;
    logic [3:0]  m_arid, m_awid;
    logic [7:0]  m_arlen, m_awlen;
    logic [2:0]  m_arsize, m_awsize;
    logic        m_arlock, m_awlock;
    logic        m_rvalid = 1'b0, m_rready;
    logic [31:0] m_rdata = '0;
    logic [1:0]  m_rresp = '0;
    logic        m_awvalid, m_awready = 1'b0;
    logic [31:0] m_awaddr;
    logic        m_wvalid, m_wready = 1'b0;
    logic [31:0] m_wdata;
    logic [3:0]  m_wstrb;
    logic        m_wlast;
    logic        m_bvalid = 1'b0, m_bready;
    logic [1:0]  m_bresp = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    excl_incr_engine #(.MAX_FAILS(MAXF)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in),
        .busy(busy), .done(done), .err(err), .result(result),
        .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
        .m_arid(m_arid), .m_arlen(m_arlen), .m_arsize(m_arsize), .m_arlock(m_arlock),
        .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata), .m_rresp(m_rresp),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
        .m_awid(m_awid), .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awlock(m_awlock),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata),
        .m_wstrb(m_wstrb), .m_wlast(m_wlast),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_start(input logic [31:0] a);
        @(negedge clk);
        start = 1'b1; addr_in = a;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic serve_read(input logic [31:0] a, input logic [31:0] d, input logic [1:0] rr);
        while (!m_arvalid) @(negedge clk);
        chk(m_araddr == a, "R2 araddr", m_araddr, a);
        chk({m_arlock, m_arsize, m_arlen, m_arid} == {1'b1, 3'b010, 8'd0, 4'd0}, "R2 ar fields",
            {16'd0, m_arlock, m_arsize, m_arlen, m_arid}, {16'd0, 1'b1, 3'b010, 8'd0, 4'd0});
        chk(busy == 1'b1, "R11 busy in read", busy, 1);
        m_arready = 1'b1;
        @(negedge clk);
        m_arready = 1'b0;
        m_rvalid = 1'b1; m_rdata = d; m_rresp = rr;
        while (!m_rready) @(negedge clk);
        @(negedge clk);
        m_rvalid = 1'b0;
    endtask

    // order: 0 AW first, 1 W first, 2 together
    task automatic serve_write(input logic [31:0] a, input logic [31:0] d, input int order,
                               input logic [1:0] br, output logic od, output logic oe,
                               output logic [31:0] ores);
        while (!(m_awvalid && m_wvalid)) @(negedge clk);
        chk(m_awaddr == a, "R3 awaddr", m_awaddr, a);
        chk(m_wdata == d, "R3 wdata", m_wdata, d);
        chk({m_awlock, m_awsize, m_awlen, m_awid, m_wlast, m_wstrb} ==
            {1'b1, 3'b010, 8'd0, 4'd0, 1'b1, 4'hF}, "R3 aw/w fields",
            {11'd0, m_awlock, m_awsize, m_awlen, m_awid, m_wlast, m_wstrb},
            {11'd0, 1'b1, 3'b010, 8'd0, 4'd0, 1'b1, 4'hF});
        if (order == 2) begin
            m_awready = 1'b1; m_wready = 1'b1;
            @(negedge clk);
            m_awready = 1'b0; m_wready = 1'b0;
        end else begin
            if (order == 0) m_awready = 1'b1; else m_wready = 1'b1;
            @(negedge clk);
            m_awready = 1'b0; m_wready = 1'b0;
            repeat (2) @(negedge clk);
            chk(m_bready == 1'b0, "R4 no bready before both", m_bready, 0);
            chk((order == 0) ? (m_wvalid && !m_awvalid) : (m_awvalid && !m_wvalid),
                "R4 pending valid held", {m_awvalid, m_wvalid}, (order == 0) ? 1 : 2);
            if (order == 0) m_wready = 1'b1; else m_awready = 1'b1;
            @(negedge clk);
            m_awready = 1'b0; m_wready = 1'b0;
        end
        m_bvalid = 1'b1; m_bresp = br;
        while (!m_bready) @(negedge clk);
        @(negedge clk);
        m_bvalid = 1'b0;
        od = done; oe = err; ores = result;
    endtask

    task automatic quiet(input int n, input string req, input bit wr_too);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (m_arvalid || (wr_too && (m_awvalid || m_wvalid))) seen = 1'b1;
        end
        chk(!seen, req, seen, 0);
    endtask

    task automatic measure_gap(input int mask);
        int g = 0;
        while (!m_arvalid) begin
            @(negedge clk);
            g++;
        end
        chk(g >= 1 && g <= mask + 1, "R6 backoff gap", g, mask + 1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk({busy, done, err, m_arvalid, m_awvalid, m_wvalid, m_bready} == 7'd0, "R1 reset outputs",
            {busy, done, err, m_arvalid, m_awvalid, m_wvalid, m_bready}, 0);
    endtask

    task automatic t_basic;
        logic d, e; logic [31:0] r;
        do_start(32'h1000_0040);
        serve_read(32'h1000_0040, 32'h41, 2'b00);
        serve_write(32'h1000_0040, 32'h42, 0, 2'b01, d, e, r);
        chk(d && !e, "R5 done pulse", {d, e}, 2);
        chk(r == 32'h42, "R5 result", r, 32'h42);
        chk(busy == 1'b0, "R11 busy low at done", busy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R5 done one cycle", done, 0);
    endtask

    task automatic t_wrap;
        logic d, e; logic [31:0] r;
        do_start(32'h2000_0000);
        serve_read(32'h2000_0000, 32'hFFFF_FFFF, 2'b00);
        serve_write(32'h2000_0000, 32'h0, 1, 2'b01, d, e, r);
        chk(d && r == 32'h0, "R3 wrap result", r, 0);
    endtask

    task automatic t_retry_once;
        logic d, e; logic [31:0] r;
        do_start(32'h3000_0100);
        serve_read(32'h3000_0100, 32'h10, 2'b00);
        serve_write(32'h3000_0100, 32'h11, 2, 2'b00, d, e, r);
        chk(!d && !e && busy, "R6 no finish on OKAY", {d, e, busy}, 1);
        measure_gap(3);
        serve_read(32'h3000_0100, 32'h7, 2'b00);
        serve_write(32'h3000_0100, 32'h8, 0, 2'b01, d, e, r);
        chk(d && !e && r == 32'h8, "R6 retry succeeds", r, 32'h8);
    endtask

    task automatic t_limit;
        logic d, e; logic [31:0] r;
        int mask = 3;
        do_start(32'h4000_0000);
        for (int k = 1; k <= MAXF; k++) begin
            serve_read(32'h4000_0000, 32'(k), 2'b00);
            serve_write(32'h4000_0000, 32'(k + 1), 2, 2'b00, d, e, r);
            if (k < MAXF) begin
                chk(!e && !d, "R7 no early err", {d, e}, 0);
                measure_gap(mask);
                mask = mask * 2 + 1;
            end
        end
        chk(e && !d, "R7 err after limit", {d, e}, 1);
        quiet(300, "R7 no read after limit", 1'b0);
    endtask

    task automatic t_berr;
        logic d, e; logic [31:0] r;
        do_start(32'h5000_0000);
        serve_read(32'h5000_0000, 32'h99, 2'b00);
        serve_write(32'h5000_0000, 32'h9A, 1, 2'b10, d, e, r);
        chk(e && !d, "R8 write error", {d, e}, 1);
        quiet(50, "R8 no retry", 1'b0);
    endtask

    task automatic t_rerr;
        do_start(32'h6000_0000);
        serve_read(32'h6000_0000, 32'h5, 2'b11);
        chk(err == 1'b1, "R9 read error", err, 1);
        quiet(50, "R9 no write issued", 1'b1);
    endtask

    task automatic t_start_busy;
        logic d, e; logic [31:0] r;
        do_start(32'h7000_0010);
        @(negedge clk);
        start = 1'b1; addr_in = 32'h7777_7770;
        @(negedge clk);
        start = 1'b0;
        chk(m_araddr == 32'h7000_0010, "R10 address kept", m_araddr, 32'h7000_0010);
        serve_read(32'h7000_0010, 32'h1, 2'b00);
        serve_write(32'h7000_0010, 32'h2, 2, 2'b01, d, e, r);
        chk(d, "R10 sequence completes", d, 1);
        quiet(20, "R10 no extra sequence", 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_wrap();
        t_retry_once();
        t_limit();
        t_berr();
        t_rerr();
        t_start_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule